// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of general-purpose pins and turns selected pin activity into interrupt requests. Every pin owns a small control word whose four-bit trigger field picks one of five detection kinds: a low level, a high level, a rising edge, a falling edge, or either edge. It can also turn detection off. Each pin is brought into the clock domain by a synchronizer. Its detector compares the synchronized value with the value it had one cycle earlier, or with the selected level.

A hit sets that pin's bit in one shared pending-flag word. Software clears pending bits by writing ones to that word. A single interrupt line is driven high whenever any pending bit is set. The register port is a plain strobe interface: writes take effect on the clock edge, and read data is registered and appears one cycle after the read strobe.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After synchronous reset every trigger field, every pending flag and the interrupt output are zero.
- R2: The control word of pin n is at byte address 4*n. Its trigger field is bits 19:16. A read returns that field in place with every other bit zero, and the read data is valid in the cycle after the read strobe.
- R3: Trigger code 0x9 sets the pin's pending flag on a 0-to-1 transition of the pin and not on a 1-to-0 transition.
- R4: Trigger code 0xA sets the pin's pending flag on a 1-to-0 transition and not on a 0-to-1 transition.
- R5: Trigger code 0xB sets the pin's pending flag on either transition.
- R6: Trigger code 0xC (high) or 0x8 (low) sets the flag on every cycle the pin holds that level, so a clear does not stick while the level remains.
- R7: Trigger code 0x0 and every code not listed above never set a flag. Writing 0 to a control word stops further detection on that pin.
- R8: The pending-flag word is at byte address 0xA0, with bit n belonging to pin n. Writing a 1 to a bit clears it, a 0 bit leaves it unchanged, and writing all ones clears every flag.
- R9: When a new hit and a clear of the same bit fall in the same cycle, the flag ends set.
- R10: The interrupt output is high exactly when at least one pending flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The checks on flag updates assume that a write strobe and its address are stable for the whole cycle they are sampled in. They also assume that pins change only between clock edges, so every transition passes through the synchronizer. The bench drives all inputs on the falling clock edge and holds each pin level for several cycles. It never writes the pending word while a pin that is configured for a level is toggling, except in the one scenario that deliberately aligns a hit with a clear.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int TRIG_W = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_BOTH = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_mode_e;

  // Decide whether the current/previous synchronized sample is a hit.
  function automatic logic trig_hit(logic [TRIG_W-1:0] mode, logic cur, logic prev);
    logic hit;
    case (mode)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      TRIG_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_async,
  input  logic              cfg_we,
  input  logic [TRIG_W-1:0] cfg_wdata,
  output logic [TRIG_W-1:0] cfg_q,
  output logic              hit_o
);
  logic cur;
  logic prev;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_async),
    .q_o (cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      cfg_q <= '0;
    end else begin
      prev <= cur;
      if (cfg_we) cfg_q <= cfg_wdata;
    end
  end

  assign hit_o = trig_hit(cfg_q, cur, prev);
endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_i,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] flags_o,
  output logic             irq_o
);
  logic [NPINS-1:0] flag_next;

  // A hit in the same cycle as a clear wins.
  always_comb begin
    flag_next = flags_o;
    if (clr_we) flag_next = flag_next & ~clr_mask;
    flag_next = flag_next | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flag_next;
      irq_o   <= |flag_next;
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int          NPINS       = 32,
  parameter int          AW          = 8,
  parameter int          DW          = 32,
  parameter int          CFG_LSB     = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  STATUS_ADDR = 8'hA0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int          IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [AW:0] CFG_END = (AW+1)'(NPINS * 4);

  logic                           cfg_hit;
  logic                           status_hit;
  logic [IDX_W-1:0]               pin_idx;
  logic [NPINS-1:0][TRIG_W-1:0]   cfg_q;
  logic [NPINS-1:0]               evt;
  logic [NPINS-1:0]               flags;
  logic [DW-1:0]                  rd_val;
  logic                           unused_bits;

  assign cfg_hit    = ({1'b0, reg_addr} < CFG_END) && (reg_addr[1:0] == 2'b00);
  assign status_hit = (reg_addr == AW'(STATUS_ADDR));
  assign pin_idx    = reg_addr[2 +: IDX_W];
  assign unused_bits = ^reg_wdata;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_irq_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .pin_async (pin_i[p]),
      .cfg_we    (reg_wr && cfg_hit && (pin_idx == IDX_W'(p))),
      .cfg_wdata (reg_wdata[CFG_LSB +: TRIG_W]),
      .cfg_q     (cfg_q[p]),
      .hit_o     (evt[p])
    );
  end

  pin_irq_status #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (evt),
    .clr_we   (reg_wr && status_hit),
    .clr_mask (reg_wdata[NPINS-1:0]),
    .flags_o  (flags),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (status_hit)
      rd_val[NPINS-1:0] = flags;
    else if (cfg_hit)
      rd_val[CFG_LSB +: TRIG_W] = cfg_q[pin_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int         NPINS       = 32,
  parameter int         AW          = 8,
  parameter int         DW          = 32,
  parameter logic [7:0] STATUS_ADDR = 8'hA0
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [NPINS-1:0] set_vec,
  input logic [NPINS-1:0] flags,
  input logic             irq_o
);
  logic status_wr;
  assign status_wr = reg_wr && (reg_addr == AW'(STATUS_ADDR));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == '0 && !irq_o));

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    (flags & ~$past(flags) & ~$past(set_vec)) == '0);

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
    status_wr |=> ((flags & $past(reg_wdata[NPINS-1:0] & ~set_vec)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flags));
endmodule

bind pin_irq_ctrl pin_irq_chk #(
  .NPINS(NPINS), .AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .set_vec   (evt),
  .flags     (flags),
  .irq_o     (irq_o)
);

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
  localparam logic [7:0] ST = 8'hA0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pin_irq_ctrl uut (
    .clk(clk), .rst(rst), .pin_i(pins), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_mode(input int pin, input logic [3:0] m);
    wr(8'(pin * 4), {12'h000, m, 16'h0000});
  endtask

  task automatic drive(input int pin, input logic v);
    @(negedge clk);
    pins[pin] = v;
    idle(6);
  endtask

  task automatic expect_status(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(ST, v);
    check(req, v, exp);
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, exp != 0});
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    expect_status("R1 status", 32'd0);
    rd(8'h00, v); check("R1 cfg0", v, 32'd0);
    rd(8'h7C, v); check("R1 cfg31", v, 32'd0);
  endtask

  task automatic test_readback();
    logic [31:0] v;
    wr(8'h14, 32'hFFFB_FFFF);
    rd(8'h14, v); check("R2 pin5 field only", v, 32'h000B_0000);
    set_mode(31, 4'hC);
    rd(8'h7C, v); check("R2 pin31", v, 32'h000C_0000);
    set_mode(5, 4'h0); set_mode(31, 4'h0);
    rd(8'h14, v); check("R2 pin5 cleared", v, 32'd0);
  endtask

  task automatic test_rise();
    set_mode(3, 4'h9);
    drive(3, 1'b1);
    expect_status("R3 rise sets", 32'h0000_0008);
    wr(ST, 32'h8);
    drive(3, 1'b0);
    expect_status("R3 fall ignored", 32'd0);
  endtask

  task automatic test_fall();
    set_mode(4, 4'hA);
    drive(4, 1'b1);
    expect_status("R4 rise ignored", 32'd0);
    drive(4, 1'b0);
    expect_status("R4 fall sets", 32'h0000_0010);
    wr(ST, 32'h10);
    set_mode(4, 4'h0);
  endtask

  task automatic test_both();
    set_mode(7, 4'hB);
    drive(7, 1'b1);
    expect_status("R5 rise sets", 32'h0000_0080);
    wr(ST, 32'h80);
    drive(7, 1'b0);
    expect_status("R5 fall sets", 32'h0000_0080);
    wr(ST, 32'h80);
    expect_status("R5 cleared", 32'd0);
  endtask

  task automatic test_level();
    set_mode(9, 4'hC);
    idle(4);
    expect_status("R6 high idle", 32'd0);
    drive(9, 1'b1);
    wr(ST, 32'h200);
    idle(2);
    expect_status("R6 high persists", 32'h0000_0200);
    drive(9, 1'b0);
    wr(ST, 32'h200);
    expect_status("R6 high released", 32'd0);
    set_mode(9, 4'h0);
    set_mode(10, 4'h8);
    idle(5);
    wr(ST, 32'h400);
    idle(2);
    expect_status("R6 low persists", 32'h0000_0400);
    drive(10, 1'b1);
    wr(ST, 32'h400);
    expect_status("R6 low released", 32'd0);
    set_mode(10, 4'h0);
    drive(10, 1'b0);
  endtask

  task automatic test_disabled();
    set_mode(13, 4'h5);
    set_mode(14, 4'hF);
    set_mode(3, 4'h0);
    drive(12, 1'b1); drive(13, 1'b1); drive(14, 1'b1); drive(3, 1'b1);
    drive(12, 1'b0); drive(13, 1'b0); drive(14, 1'b0); drive(3, 1'b0);
    expect_status("R7 off and unlisted codes", 32'd0);
    set_mode(13, 4'h0); set_mode(14, 4'h0);
  endtask

  task automatic test_w1c();
    set_mode(3, 4'h9);
    set_mode(7, 4'hB);
    drive(3, 1'b1); drive(7, 1'b1);
    expect_status("R8 two pending", 32'h0000_0088);
    wr(ST, 32'h0);
    expect_status("R8 zero write", 32'h0000_0088);
    wr(ST, 32'h8);
    expect_status("R8 selective", 32'h0000_0080);
    wr(ST, 32'hFFFF_FFFF);
    expect_status("R8 all ones", 32'd0);
    check("R10 irq low", {31'd0, irq_o}, 32'd0);
    drive(3, 1'b0); drive(7, 1'b0);
    wr(ST, 32'hFFFF_FFFF);
  endtask

  task automatic test_collision();
    drive(7, 1'b1);
    expect_status("R10 one flag", 32'h0000_0080);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = ST; reg_wdata = 32'h88;
    @(negedge clk); reg_wr = 1'b0;
    expect_status("R9 set beats clear", 32'h0000_0008);
    wr(ST, 32'hFFFF_FFFF);
    set_mode(3, 4'h0); set_mode(7, 4'h0);
    expect_status("R10 idle", 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    test_reset();
    test_readback();
    test_rise();
    test_fall();
    test_both();
    test_level();
    test_disabled();
    test_w1c();
    test_collision();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule